// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it decides whether the operand should come from the value read out of the register file or from a result that has not yet been written back. A result that has not been written back is still held in either the execute/memory pipeline register or the memory/writeback pipeline register. The block takes the two source register numbers of the instruction now in execute. It also takes the destination register number and write enable of each of the two later stages. It returns one 2-bit select code per operand, and these codes steer the operand multiplexers that sit outside the block.

The block has no clock and holds no state. Both selects follow the inputs within the same cycle. The older of the two in-flight results only wins when the younger one does not match. Register zero is hard-wired and is never bypassed.

Top module: `fwd_select_unit`

## Requirements
- R1: Each select output takes exactly one of three codes: 2'b00 selects the register-file value, 2'b10 selects the execute/memory result, and 2'b01 selects the memory/writeback result. The code 2'b11 never appears.
- R2: An operand's select is 2'b10 when the execute/memory write enable is high, its destination is nonzero, and its destination equals that operand's source number.
- R3: When R2 does not apply, an operand's select is 2'b01 when the memory/writeback write enable is high, its destination is nonzero, and its destination equals that operand's source number.
- R4: When both later stages meet their conditions for the same operand, the execute/memory result (2'b10) is chosen over the memory/writeback result.
- R5: Operand A is compared only against `src_a` and operand B only against `src_b`. A match on one operand does not change the other operand's select.
- R6: A destination of register 0 never causes bypassing, even with its write enable high, so a source of 0 always yields 2'b00.
- R7: When both operands name the same in-flight destination, both selects assert the same bypass code.
- R8: With no match, or with both write enables low, both selects are 2'b00.
- R9: The selects are purely combinational and reflect a change of any input within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | Source register number for operand A |
| src_b | input | 5 | Source register number for operand B |
| xm_dst | input | 5 | Destination register held in the execute/memory register |
| xm_wen | input | 1 | Register-write enable of the execute/memory stage |
| mw_dst | input | 5 | Destination register held in the memory/writeback register |
| mw_wen | input | 1 | Register-write enable of the memory/writeback stage |
| sel_a | output | 2 | Bypass select code for operand A |
| sel_b | output | 2 | Bypass select code for operand B |

## Verification
A bypass from the execute/memory stage and a bypass from the memory/writeback stage can apply to the same operand at once. This happens when two back-to-back producers write the same register. The bench provokes this with directed vectors in which both destinations equal one source. It then checks that the younger producer's code is reported. The same collision is also exercised in vectors where the shared register is 0, or where one of the two write enables is low. A behavioural reference, fed with register numbers drawn from a small range so that matches are frequent, judges every vector on every clock.

// File: rtl/fwd_pkg.sv
// Package: shared types for the operand bypass selector.
// Assumes register numbers are narrow enough to compare in one level.
package fwd_pkg;

    // Operand source codes; the operand muxes decode these exact values.
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MEMWB   = 2'b01,
        SEL_EXMEM   = 2'b10
    } fwd_sel_t;

    // Stage index used when stage matches are collected in a vector.
    localparam int STG_XM   = 0;
    localparam int STG_MW   = 1;
    localparam int NUM_STG  = 2;

endpackage

// File: rtl/fwd_stage_match.sv
// Module: fwd_stage_match
// Decides whether one later pipeline stage holds the value a source
// register needs. Assumes register 0 is a constant and never written.
module fwd_stage_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wen,
    output logic          hit
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    // Match only a real write to a nonzero register equal to the source.
    always_comb begin
        hit = wen && (dst != ZERO_REG) && (dst == src);
    end

endmodule

// File: rtl/fwd_operand_sel.sv
// Module: fwd_operand_sel
// Produces the bypass select for one ALU operand from the match results
// of the later stages. Assumes stage 0 is the younger producer.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]         src,
    input  logic [NUM_STG*AW-1:0] stg_dst,
    input  logic [NUM_STG-1:0]    stg_wen,
    output fwd_sel_t              sel
);

    logic [NUM_STG-1:0] stg_hit;

    // One comparator per later stage.
    generate
        for (genvar s = 0; s < NUM_STG; s++) begin : g_stage
            fwd_stage_match #(.AW(AW)) match_i (
                .src (src),
                .dst (stg_dst[s*AW +: AW]),
                .wen (stg_wen[s]),
                .hit (stg_hit[s])
            );
        end
    endgenerate

    // Pick the youngest matching producer, else the register file.
    always_comb begin
        if (stg_hit[STG_XM])
            sel = SEL_EXMEM;
        else if (stg_hit[STG_MW])
            sel = SEL_MEMWB;
        else
            sel = SEL_REGFILE;
    end

    // Guards on the select, checked whenever any input moves.
    always_comb begin
        AST_LEGAL_CODE: assert (sel != 2'b11)
            else $error("illegal select code"); // R1
        AST_YOUNGER_WINS: assert (!stg_hit[STG_XM] || sel == SEL_EXMEM)
            else $error("execute/memory match not chosen"); // R4
        AST_ZERO_SRC: assert (src != '0 || sel == SEL_REGFILE)
            else $error("register zero bypassed"); // R6
        AST_IDLE_REGFILE: assert ((|stg_wen) || sel == SEL_REGFILE)
            else $error("bypass with no write enable"); // R8
    end

endmodule

// File: rtl/fwd_select_unit.sv
// Module: fwd_select_unit (top)
// Combinational bypass selection for both execute-stage ALU operands.
// Assumes the operand muxes, register file and stall logic live outside.
module fwd_select_unit
    import fwd_pkg::*;
#(
    parameter int AW     = 5,
    parameter int NUM_OP = 2
) (
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic [AW-1:0] xm_dst,
    input  logic          xm_wen,
    input  logic [AW-1:0] mw_dst,
    input  logic          mw_wen,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b
);

    localparam int DW = NUM_STG * AW;

    logic [NUM_OP*AW-1:0] src_vec;
    logic [DW-1:0]        dst_vec;
    logic [NUM_STG-1:0]   wen_vec;
    fwd_sel_t             sel_vec [NUM_OP];

    // Gather the stage fields in stage-index order.
    always_comb begin
        src_vec = {src_b, src_a};
        dst_vec = '0;
        dst_vec[STG_XM*AW +: AW] = xm_dst;
        dst_vec[STG_MW*AW +: AW] = mw_dst;
        wen_vec = '0;
        wen_vec[STG_XM] = xm_wen;
        wen_vec[STG_MW] = mw_wen;
    end

    // One independent selector per operand.
    generate
        for (genvar o = 0; o < NUM_OP; o++) begin : g_op
            fwd_operand_sel #(.AW(AW)) opsel_i (
                .src     (src_vec[o*AW +: AW]),
                .stg_dst (dst_vec),
                .stg_wen (wen_vec),
                .sel     (sel_vec[o])
            );
        end
    endgenerate

    // Drive the plain output ports.
    always_comb begin
        sel_a = sel_vec[0];
        sel_b = sel_vec[1];
    end

    // Operands with equal sources must agree.
    always_comb begin
        AST_SHARED_PRODUCER: assert (src_a != src_b || sel_a == sel_b)
            else $error("equal sources disagree"); // R7
    end

endmodule

// File: tb/fwd_select_unit_tb.sv
`timescale 1ns/1ps
// Bench: directed and pseudo-random vectors judged by a behavioural model.
module fwd_select_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_a = '0, src_b = '0, xm_dst = '0, mw_dst = '0;
    logic       xm_wen = 1'b0, mw_wen = 1'b0;
    logic [1:0] sel_a, sel_b;
    int         errors = 0;
    int         checks = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fwd_select_unit dut_i (
        .src_a(src_a), .src_b(src_b),
        .xm_dst(xm_dst), .xm_wen(xm_wen),
        .mw_dst(mw_dst), .mw_wen(mw_wen),
        .sel_a(sel_a), .sel_b(sel_b)
    );

    // Behavioural reference: youngest valid nonzero producer wins.
    function automatic logic [1:0] model(input logic [4:0] s);
        int pick = 0;
        if (mw_wen && mw_dst == s && s != 0) pick = 1;
        if (xm_wen && xm_dst == s && s != 0) pick = 2;
        return pick[1:0];
    endfunction

    task automatic check(input string tag);
        logic [1:0] ea = model(src_a);
        logic [1:0] eb = model(src_b);
        checks++;
        if (sel_a !== ea || sel_b !== eb) begin
            errors++;
            $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", tag, sel_a, sel_b, ea, eb);
        end
    endtask

    task automatic expect_codes(input string tag, input logic [1:0] ea, input logic [1:0] eb);
        checks++;
        if (sel_a !== ea || sel_b !== eb) begin
            errors++;
            $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", tag, sel_a, sel_b, ea, eb);
        end
    endtask

    task automatic apply(input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] xd, input logic xw,
                         input logic [4:0] md, input logic mw);
        @(negedge clk);
        src_a = a; src_b = b; xm_dst = xd; xm_wen = xw; mw_dst = md; mw_wen = mw;
        #1;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        expect_codes("R8 reset state", 2'b00, 2'b00);

        apply(5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b0);
        expect_codes("R2 xm to A", 2'b10, 2'b00);
        apply(5'd3, 5'd4, 5'd4, 1'b1, 5'd9, 1'b0);
        expect_codes("R5 xm to B only", 2'b00, 2'b10);
        apply(5'd3, 5'd4, 5'd3, 1'b0, 5'd9, 1'b0);
        expect_codes("R2 xm wen low", 2'b00, 2'b00);
        apply(5'd7, 5'd8, 5'd1, 1'b0, 5'd8, 1'b1);
        expect_codes("R3 mw to B", 2'b00, 2'b01);
        apply(5'd7, 5'd8, 5'd1, 1'b0, 5'd7, 1'b1);
        expect_codes("R3 mw to A", 2'b01, 2'b00);
        apply(5'd6, 5'd2, 5'd6, 1'b1, 5'd6, 1'b1);
        expect_codes("R4 both stages match A", 2'b10, 2'b00);
        apply(5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b1);
        expect_codes("R4 xm wen low falls to mw", 2'b01, 2'b01);
        apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        expect_codes("R6 register zero", 2'b00, 2'b00);
        apply(5'd5, 5'd5, 5'd0, 1'b1, 5'd5, 1'b1);
        expect_codes("R6 zero xm dst lets mw through", 2'b01, 2'b01);
        apply(5'd12, 5'd12, 5'd12, 1'b1, 5'd3, 1'b1);
        expect_codes("R7 shared producer", 2'b10, 2'b10);
        apply(5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1);
        expect_codes("R8 no match", 2'b00, 2'b00);
        apply(5'd31, 5'd30, 5'd30, 1'b1, 5'd31, 1'b1);
        expect_codes("R5 split sources", 2'b01, 2'b10);

        // R9: change inputs mid-cycle, look before the next edge.
        @(posedge clk);
        #1;
        src_a = 5'd9; xm_dst = 5'd9; xm_wen = 1'b1; mw_wen = 1'b0;
        #0.5;
        expect_codes("R9 same-cycle response", 2'b10, model(src_b));

        // Dense pseudo-random sweep; every code checked, R1 legality included.
        for (int i = 0; i < 2000; i++) begin
            apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  5'($urandom_range(0, 3)), 1'($urandom),
                  5'($urandom_range(0, 3)), 1'($urandom));
            check("R1 R4 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule